// File: doc/BRIEF.md
# RGMII Receive Double-Data-Rate Decoder

This block sits right behind the input pins of a reduced-pin gigabit receive interface. The physical layer device sends a 4-bit data bus and one control line, and both change on each half of a continuous receive clock. The clock runs at 125 MHz, 25 MHz or 2.5 MHz. The block samples the bus and the control line on the rising edge and on the falling edge. It joins the two nibbles into one byte and turns the two control samples into a data-valid flag and an error flag. It gives out one byte, one valid bit and one error bit on each rising edge.

The control line is coded so that it does not toggle during normal traffic. The rising-half sample is the data-valid flag. The falling-half sample carries data-valid exclusive-or error. The block undoes this coding with a single XOR of the two samples from the same clock period. Input delay lines, the crossing into the MAC clock domain, frame parsing and speed detection sit in other blocks.

Top module: `rgmii_rx_ddr_decoder`

## Requirements
- R1: The nibble on `rxd` sampled at the rising edge of `clk` is output as `rx_data[3:0]`.
- R2: The nibble on `rxd` sampled at the falling edge of the same clock period is output as `rx_data[7:4]`.
- R3: `rx_valid` equals the level of `rx_ctl` sampled at the rising edge.
- R4: `rx_err` equals the rising-edge `rx_ctl` sample XOR the falling-edge `rx_ctl` sample.
- R5: A control pair high/high gives valid=1 err=0. High/low gives valid=1 err=1. Low/low gives valid=0 err=0.
- R6: A control pair low (rising) / high (falling) gives valid=0 err=1 and is passed out unchanged.
- R7: The byte, valid and error of one clock period all appear together after the next rising edge of `clk`. This is a fixed latency of one cycle, counted from the rising-edge sample.
- R8: A synchronous active-high `rst` clears `rx_valid`, `rx_err` and `rx_data` to zero at the next rising edge.
- R9: The data byte is assembled and output even when valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Continuous receive clock; both edges sample |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 4 | Double-rate receive nibble bus |
| rx_ctl | input | 1 | Double-rate coded receive control line |
| rx_data | output | 8 | Reassembled byte, low nibble from the rising half |
| rx_valid | output | 1 | Decoded data-valid flag |
| rx_err | output | 1 | Decoded receive error flag |

## Verification
Assertions inside the assembly stage check on every rising edge four things. The output nibbles and the valid bit follow the two half-cycle samples of the period before. The error bit is the XOR of the two control samples. The idle code and the low/high code give their fixed outputs, and reset clears the flags. Only the bench scenarios show what comes before those samples. These are the real timing on the pins and the nibble order seen from outside. They also cover the one-cycle latency against the driven stream, because the bench encodes each byte and flag pair as a transmitter would and sweeps all 256 byte values with all four control codes.

// File: rtl/rgmii_rx_pkg.sv
package rgmii_rx_pkg;

    localparam int NIB_W_DEFAULT = 4;
    localparam int NUM_PHASES    = 2;
    localparam int PHASE_RISE    = 0;
    localparam int PHASE_FALL    = 1;

    typedef struct packed {
        logic valid;
        logic err;
    } rx_flags_t;

    // Undo the transition-minimising control coding of one clock period.
    function automatic rx_flags_t decode_ctl(input logic rise_s, input logic fall_s);
        rx_flags_t f;
        f.valid = rise_s;
        f.err   = rise_s ^ fall_s;
        return f;
    endfunction

endpackage

// File: rtl/rgmii_rx_lane.sv
module rgmii_rx_lane #(
    parameter int NIB_W   = 4,
    parameter bit FALLING = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] rxd_i,
    input  logic             ctl_i,
    output logic [NIB_W-1:0] nib_o,
    output logic             ctl_o
);

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge clk) begin
                if (rst) begin
                    nib_o <= '0;
                    ctl_o <= 1'b0;
                end else begin
                    nib_o <= rxd_i;
                    ctl_o <= ctl_i;
                end
            end
        end else begin : g_rise
            always_ff @(posedge clk) begin
                if (rst) begin
                    nib_o <= '0;
                    ctl_o <= 1'b0;
                end else begin
                    nib_o <= rxd_i;
                    ctl_o <= ctl_i;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rgmii_rx_assemble.sv
module rgmii_rx_assemble
    import rgmii_rx_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NIB_W-1:0]   lo_nib_i,
    input  logic [NIB_W-1:0]   hi_nib_i,
    input  logic               rise_ctl_i,
    input  logic               fall_ctl_i,
    output logic [2*NIB_W-1:0] data_o,
    output logic               valid_o,
    output logic               err_o
);

    localparam int BYTE_W = 2 * NIB_W;

    rx_flags_t flags_d;
    logic [BYTE_W-1:0] byte_d;

    always_comb begin
        flags_d = decode_ctl(rise_ctl_i, fall_ctl_i);
        byte_d  = {hi_nib_i, lo_nib_i};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            data_o  <= byte_d;
            valid_o <= flags_d.valid;
            err_o   <= flags_d.err;
        end
    end

    // R8: reset clears the flags and the byte
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid_o && !err_o && data_o == '0));

    // R1: low nibble follows the rising-half sample one edge later
    a_r1_low_nibble: assert property (@(posedge clk) disable iff (rst)
        !rst |=> data_o[NIB_W-1:0] == $past(lo_nib_i));

    // R2: high nibble follows the falling-half sample one edge later
    a_r2_high_nibble: assert property (@(posedge clk) disable iff (rst)
        !rst |=> data_o[BYTE_W-1:NIB_W] == $past(hi_nib_i));

    // R3: valid tracks the rising-half control sample
    a_r3_valid_rise: assert property (@(posedge clk) disable iff (rst)
        !rst |=> valid_o == $past(rise_ctl_i));

    // R4: error is the XOR of the two control samples
    a_r4_err_xor: assert property (@(posedge clk) disable iff (rst)
        !rst |=> err_o == ($past(rise_ctl_i) != $past(fall_ctl_i)));

    // R5: low on both halves means no frame
    a_r5_idle_code: assert property (@(posedge clk) disable iff (rst)
        (!rise_ctl_i && !fall_ctl_i) |=> (!valid_o && !err_o));

    // R6: low then high passes out as error without valid
    a_r6_low_high: assert property (@(posedge clk) disable iff (rst)
        (!rise_ctl_i && fall_ctl_i) |=> (!valid_o && err_o));

endmodule

// File: rtl/rgmii_rx_ddr_decoder.sv
module rgmii_rx_ddr_decoder
    import rgmii_rx_pkg::*;
#(
    parameter int NIB_W = NIB_W_DEFAULT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NIB_W-1:0]   rxd,
    input  logic               rx_ctl,
    output logic [2*NIB_W-1:0] rx_data,
    output logic               rx_valid,
    output logic               rx_err
);

    logic [NIB_W-1:0] nib_s [NUM_PHASES];
    logic             ctl_s [NUM_PHASES];

    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phase
        rgmii_rx_lane #(
            .NIB_W   (NIB_W),
            .FALLING (g == PHASE_FALL)
        ) u_lane (
            .clk   (clk),
            .rst   (rst),
            .rxd_i (rxd),
            .ctl_i (rx_ctl),
            .nib_o (nib_s[g]),
            .ctl_o (ctl_s[g])
        );
    end

    rgmii_rx_assemble #(
        .NIB_W (NIB_W)
    ) u_assemble (
        .clk        (clk),
        .rst        (rst),
        .lo_nib_i   (nib_s[PHASE_RISE]),
        .hi_nib_i   (nib_s[PHASE_FALL]),
        .rise_ctl_i (ctl_s[PHASE_RISE]),
        .fall_ctl_i (ctl_s[PHASE_FALL]),
        .data_o     (rx_data),
        .valid_o    (rx_valid),
        .err_o      (rx_err)
    );

endmodule

// File: tb/tb_rgmii_rx_ddr_decoder.sv
`timescale 1ns/1ps
module tb_rgmii_rx_ddr_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rxd = '0;
    logic       rx_ctl = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rgmii_rx_ddr_decoder dut (
        .clk      (clk),
        .rst      (rst),
        .rxd      (rxd),
        .rx_ctl   (rx_ctl),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_err   (rx_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] pb;
        logic       pdv, per;
        bit         have_prev;

        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 reset valid", int'(rx_valid), 0);
        chk("R8 reset err", int'(rx_err), 0);
        chk("R8 reset data", int'(rx_data), 0);

        @(negedge clk) #1;
        rst = 1'b0;

        // Loopback sweep of every byte with every control code.
        // The encoder drives the rising half as {byte[3:0], dv} and the falling half as {byte[7:4], dv^er}.
        have_prev = 1'b0;
        pb = '0; pdv = 1'b0; per = 1'b0;
        for (int i = 0; i <= 1024; i++) begin
            logic [7:0] b;
            logic       dv, er;
            b  = 8'(i % 256);
            dv = ((i / 256) & 2) != 0;
            er = ((i / 256) & 1) != 0;
            @(negedge clk) #1;
            rxd    = b[3:0];
            rx_ctl = dv;
            @(posedge clk) #1;
            if (have_prev) begin
                // R7: the previous period shows up right after this rising edge
                chk("R1 low nibble", int'(rx_data[3:0]), int'(pb[3:0]));
                chk("R2 high nibble", int'(rx_data[7:4]), int'(pb[7:4]));
                chk("R3 valid", int'(rx_valid), int'(pdv));
                chk("R4 err", int'(rx_err), int'(per));
                if (pdv && !per)  chk("R5 high/high", int'({rx_valid, rx_err}), 2);
                if (pdv && per)   chk("R5 high/low", int'({rx_valid, rx_err}), 3);
                if (!pdv && !per) chk("R5 low/low", int'({rx_valid, rx_err}), 0);
                if (!pdv && per)  chk("R6 low/high", int'({rx_valid, rx_err}), 1);
                if (!pdv)         chk("R9 data while idle", int'(rx_data), int'(pb));
            end
            #1;
            rxd    = b[7:4];
            rx_ctl = dv ^ er;
            pb = b; pdv = dv; per = er; have_prev = 1'b1;
        end

        // R7: the output stays put until the next rising edge, then takes the new period
        @(negedge clk) #1;
        rxd = 4'h5; rx_ctl = 1'b1;
        @(posedge clk) #2;
        rxd = 4'hA; rx_ctl = 1'b1;
        @(negedge clk) #1;
        chk("R7 before edge", int'(rx_data), int'(pb));
        rxd = 4'h0; rx_ctl = 1'b0;
        @(posedge clk) #1;
        chk("R7 latency data", int'(rx_data), 8'hA5);
        chk("R7 latency flags", int'({rx_valid, rx_err}), 2);

        // R8: reset in the middle of a frame
        @(negedge clk) #1;
        rxd = 4'hF; rx_ctl = 1'b1;
        @(posedge clk) #2;
        rxd = 4'hF; rx_ctl = 1'b0;
        @(negedge clk) #1;
        rst = 1'b1;
        rxd = 4'hF; rx_ctl = 1'b1;
        @(posedge clk) #1;
        chk("R8 mid reset valid", int'(rx_valid), 0);
        chk("R8 mid reset err", int'(rx_err), 0);
        chk("R8 mid reset data", int'(rx_data), 0);
        @(negedge clk) #1;
        rst = 1'b0;
        @(posedge clk) #1;
        finish_run();
    end

endmodule